// File: doc/BRIEF.md
# Receive Byte Queue with Threshold and Idle-Line Interrupts

This block buffers the bytes a serial receiver produces until software reads them. Each byte presented with a valid strobe goes into a 16-entry first-in first-out queue. The oldest byte is always visible on the read data output, and a read strobe removes it. A control write sets two things: whether the queue is enabled, and which fill threshold raises the data interrupt. The threshold can be 1, 4, 8 or 14 bytes.

A burst that stops short of the threshold would otherwise sit in the queue with no interrupt. To cover that case, a second interrupt fires once the line has been quiet for four character times while data is waiting. One character time is ten baud ticks.

A byte that arrives while the queue is full is dropped and sets a sticky overrun flag. A status-read strobe clears that flag. Writing the control register with the enable bit low empties the queue.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After reset the queue is disabled and empty, with trigger code 00. Both interrupts and the overrun flag are low, and `rd_data` reads 0.
- R2: A write on `ctrl_we` loads the control fields. Bit 0 of `ctrl_wdata` is the enable. Bits 7:6 select the trigger level: 00 = 1 byte, 01 = 4 bytes, 10 = 8 bytes, 11 = 14 bytes. For example, 0xC1 means enabled with a 14-byte trigger.
- R3: `rd_data` shows the oldest stored byte, and bytes leave in arrival order. An `rd_en` pulse on a non-empty queue removes one byte. `rd_data` is 0 while the queue is empty.
- R4: The queue holds 16 bytes. A byte that arrives while the queue is full, with no read in the same cycle, is discarded and sets `overrun` on the next cycle. A byte that arrives together with a read while full is stored.
- R5: `overrun` stays high until a `stat_rd` pulse clears it. A new overrun in the same cycle as `stat_rd` takes precedence over the clear.
- R6: `data_irq` is high exactly while the queue is enabled and its fill level is at or above the selected trigger level.
- R7: `timeout_irq` rises after 40 `baud_tick` pulses have been counted with neither a stored byte nor a read since the last such event, while the queue is enabled and non-empty.
- R8: Any accepted byte or read clears `timeout_irq` and restarts the count. `timeout_irq` is never high while the queue is empty.
- R9: A control write with bit 0 low empties the queue and clears both interrupts. While the queue is disabled, incoming bytes are ignored and reads do nothing.
- R10: A read strobe on an empty queue changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Receiver presents a byte this cycle |
| rx_data | input | 8 | Received byte |
| rd_en | input | 1 | Remove the oldest byte |
| rd_data | output | 8 | Oldest byte, 0 when empty |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control value: bit 0 enable, bits 7:6 trigger code |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| baud_tick | input | 1 | One pulse per serial bit time |
| data_irq | output | 1 | Fill level at or above trigger |
| timeout_irq | output | 1 | Data waiting on a quiet line |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The assertions take it for granted that every strobe is a level sampled on the clock edge. A strobe held for several cycles therefore counts as several events: several bytes, several reads, or several ticks. `baud_tick` is treated as an independent count enable, not tied to `rx_valid`. The stimulus drives every input at the falling edge and holds it for exactly one cycle. It keeps ticks sparse and sometimes idle for long stretches, so that both the 39-tick and 40-tick sides of the timeout are reached. Control writes are never issued in the same cycle as a byte or a read, so flush-versus-push ordering is never relied on.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

  typedef enum logic [1:0] {
    TRIG_1  = 2'b00,
    TRIG_4  = 2'b01,
    TRIG_8  = 2'b10,
    TRIG_14 = 2'b11
  } trig_sel_e;

  typedef struct packed {
    trig_sel_e trig;
    logic      en;
  } rxq_ctrl_t;

  function automatic int unsigned trig_bytes(trig_sel_e sel);
    case (sel)
      TRIG_1:  return 1;
      TRIG_4:  return 4;
      TRIG_8:  return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_storage.sv
module rxq_storage #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           push,
  input  logic                           pop,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      if (push && !pop)      cnt_d = cnt_q + 1'b1;
      else if (pop && !push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wptr_q] <= wdata;
  end

  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign head  = empty ? '0 : mem[rptr_q];

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT+1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = tick && (cnt_q != LIM);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LIM);

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import uart_rxq_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DEPTH         = 16,
  parameter int CHAR_BITS     = 10,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  input  logic              stat_rd,
  input  logic              baud_tick,
  output logic              data_irq,
  output logic              timeout_irq,
  output logic              overrun
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int LIMIT = CHAR_BITS * TIMEOUT_CHARS;

  rxq_ctrl_t         ctrl_q, ctrl_d;
  logic              ovr_q, ovr_d;
  logic              flush, push, pop, drop, restart;
  logic              empty, full, expired;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  level;

  // control register next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.en   = ctrl_wdata[0];
      ctrl_d.trig = trig_sel_e'(ctrl_wdata[7:6]);
    end
  end

  assign flush = ctrl_we && !ctrl_wdata[0];
  assign pop   = rd_en && ctrl_q.en && !empty;
  assign push  = rx_valid && ctrl_q.en && (!full || pop);
  assign drop  = rx_valid && ctrl_q.en && full && !pop;

  always_comb begin
    ovr_d = ovr_q;
    if (drop)         ovr_d = 1'b1;
    else if (stat_rd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '{trig: TRIG_1, en: 1'b0};
      ovr_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ovr_q  <= ovr_d;
    end
  end

  rxq_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .pop   (pop),
    .wdata (rx_data),
    .head  (rd_data),
    .count (count),
    .empty (empty),
    .full  (full)
  );

  assign restart = flush || push || pop || empty || !ctrl_q.en;

  rxq_timeout #(.LIMIT(LIMIT)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .tick    (baud_tick),
    .expired (expired)
  );

  assign level       = CNT_W'(trig_bytes(ctrl_q.trig));
  assign data_irq    = ctrl_q.en && (count >= level);
  assign timeout_irq = expired && !empty;
  assign overrun     = ovr_q;

endmodule

// File: rtl/uart_rxq_chk.sv
module uart_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             rd_en,
  input logic             stat_rd,
  input logic             baud_tick,
  input logic             ctrl_we,
  input logic [7:0]       ctrl_wdata,
  input logic [7:0]       rd_data,
  input logic             data_irq,
  input logic             timeout_irq,
  input logic             overrun,
  input logic             en,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             push,
  input logic             pop
);
  // R3
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !ctrl_we) |=> (count == $past(count) - 1'b1));

  // R4
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R4
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && en && full && !rd_en) |=> overrun);

  // R5
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(rx_valid && en && full && !rd_en)) |=> !overrun);

  // R7
  tmo_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_irq) |-> $past(baud_tick));

  // R8
  tmo_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_irq |-> (count != '0));

  // R8
  tmo_push_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !timeout_irq);

  // R9
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !ctrl_wdata[0]) |=> (!data_irq && !timeout_irq && rd_data == 8'h00));

endmodule

bind uart_rx_fifo_irq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_valid    (rx_valid),
  .rd_en       (rd_en),
  .stat_rd     (stat_rd),
  .baud_tick   (baud_tick),
  .ctrl_we     (ctrl_we),
  .ctrl_wdata  (ctrl_wdata),
  .rd_data     (rd_data),
  .data_irq    (data_irq),
  .timeout_irq (timeout_irq),
  .overrun     (overrun),
  .en          (ctrl_q.en),
  .full        (full),
  .count       (count),
  .push        (push),
  .pop         (pop)
);

// File: tb/tb_uart_rx_fifo_irq.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_valid, rd_en, ctrl_we, stat_rd, baud_tick;
  logic [7:0] rx_data, ctrl_wdata, rd_data;
  logic       data_irq, timeout_irq, overrun;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  uart_rx_fifo_irq dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_en(rd_en), .rd_data(rd_data), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_rd(stat_rd), .baud_tick(baud_tick), .data_irq(data_irq),
    .timeout_irq(timeout_irq), .overrun(overrun)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] mq[$];
  int  mt;
  bit  men, mo;
  int  mtrig;
  int  sz;
  bit  m_pop, m_push, m_drop, m_flush, m_rst;

  function automatic int lvl(int code);
    return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); mt = 0; men = 0; mo = 0; mtrig = 0;
    end else begin
      sz      = mq.size();
      m_pop   = rd_en && men && sz > 0;
      m_push  = rx_valid && men && (sz < 16 || m_pop);
      m_drop  = rx_valid && men && sz == 16 && !m_pop;
      m_flush = ctrl_we && !ctrl_wdata[0];
      m_rst   = m_flush || m_push || m_pop || sz == 0 || !men;
      if (m_flush) mq.delete();
      else begin
        if (m_pop)  void'(mq.pop_front());
        if (m_push) mq.push_back(rx_data);
      end
      if (m_rst) mt = 0;
      else if (baud_tick && mt < 40) mt++;
      if (m_drop) mo = 1;
      else if (stat_rd) mo = 0;
      if (ctrl_we) begin men = ctrl_wdata[0]; mtrig = int'(ctrl_wdata[7:6]); end
    end
    #1;
    if (rst_n) begin
      check("R3 rd_data", 32'(rd_data), (mq.size() > 0) ? 32'(mq[0]) : 32'h0);
      check("R6 data_irq", 32'(data_irq), 32'(men && mq.size() >= lvl(mtrig)));
      check("R7 timeout_irq", 32'(timeout_irq), 32'(mt == 40 && mq.size() != 0));
      check("R5 overrun", 32'(overrun), 32'(mo));
    end
  end

  task automatic idle_inputs();
    rx_valid = 0; rx_data = 0; rd_en = 0; ctrl_we = 0; ctrl_wdata = 0;
    stat_rd = 0; baud_tick = 0;
  endtask

  task automatic cyc(bit v, logic [7:0] d, bit rd, bit tk, bit srd);
    @(negedge clk);
    idle_inputs();
    rx_valid = v; rx_data = d; rd_en = rd; baud_tick = tk; stat_rd = srd;
  endtask

  task automatic wr_ctrl(logic [7:0] val);
    @(negedge clk);
    idle_inputs();
    ctrl_we = 1; ctrl_wdata = val;
  endtask

  task automatic settle();
    @(negedge clk);
    idle_inputs();
    @(posedge clk); #2;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_data", 32'(rd_data), 0);
    check("R1 data_irq", 32'(data_irq), 0);
    check("R1 timeout_irq", 32'(timeout_irq), 0);
    check("R1 overrun", 32'(overrun), 0);
    rst_n = 1;

    // R9: disabled queue ignores bytes
    cyc(1, 8'h5A, 0, 0, 0);
    settle();
    check("R9 disabled ignores byte", 32'(rd_data), 0);

    // R2: 0xC1 -> enabled, 14-byte trigger; 11-byte burst
    wr_ctrl(8'hC1);
    for (int i = 0; i < 11; i++) cyc(1, 8'(8'h10 + i), 0, 0, 0);
    settle();
    check("R2 no irq below 14", 32'(data_irq), 0);
    check("R3 head is first byte", 32'(rd_data), 32'h10);
    for (int i = 0; i < 39; i++) cyc(0, 0, 0, 1, 0);
    settle();
    check("R7 no timeout at 39 ticks", 32'(timeout_irq), 0);
    cyc(0, 0, 0, 1, 0);
    settle();
    check("R7 timeout at 40 ticks", 32'(timeout_irq), 1);
    cyc(0, 0, 1, 0, 0);
    settle();
    check("R8 read clears timeout", 32'(timeout_irq), 0);
    check("R3 next byte", 32'(rd_data), 32'h11);
    for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1, 0);
    cyc(1, 8'h77, 0, 0, 0);
    settle();
    check("R8 byte clears timeout", 32'(timeout_irq), 0);
    for (int i = 0; i < 14; i++) cyc(0, 0, 1, 0, 0);
    settle();
    check("R10 drained empty", 32'(rd_data), 0);
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 45; i++) cyc(0, 0, 0, 1, 0);
    settle();
    check("R8 no timeout when empty", 32'(timeout_irq), 0);

    // R2/R6: trigger 01 -> 4 bytes
    wr_ctrl(8'h41);
    for (int i = 0; i < 3; i++) cyc(1, 8'(i), 0, 0, 0);
    settle();
    check("R6 3 below trig4", 32'(data_irq), 0);
    cyc(1, 8'h03, 0, 0, 0);
    settle();
    check("R6 4 at trig4", 32'(data_irq), 1);

    // R4: fill to 16 then overflow
    wr_ctrl(8'h81);
    for (int i = 4; i < 16; i++) cyc(1, 8'(i), 0, 0, 0);
    cyc(1, 8'hEE, 0, 0, 0);
    settle();
    check("R4 overrun on full", 32'(overrun), 1);
    cyc(1, 8'hAB, 1, 0, 0);
    settle();
    check("R4 head after push+pop", 32'(rd_data), 32'h01);
    cyc(0, 0, 0, 0, 1);
    settle();
    check("R5 stat_rd clears", 32'(overrun), 0);
    cyc(1, 8'hCD, 0, 0, 1);
    settle();
    check("R5 set beats clear", 32'(overrun), 1);

    // R9: disable flushes
    wr_ctrl(8'h80);
    settle();
    check("R9 flush empties", 32'(rd_data), 0);
    check("R9 flush clears irq", 32'(data_irq), 0);
    cyc(0, 0, 0, 0, 1);

    // mixed traffic
    for (int p = 0; p < 8; p++) begin
      wr_ctrl(8'(((p % 4) << 6) | 1));
      for (int i = 0; i < 400; i++) begin
        int r;
        r = $urandom_range(0, 99);
        cyc((p % 2 == 0) ? (r < 30) : (r < 8 && i < 200),
            8'($urandom), (r >= 85) && (p != 3), ($urandom_range(0, 2) == 0),
            ($urandom_range(0, 30) == 0));
      end
    end
    settle();
    settle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule